// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask

This block arbitrates thirty-two external interrupt levels on behalf of a CPU. Level 0 is the most urgent and level 31 the least. Devices raise a request on a level and supply an 8-bit descriptor with it. The controller keeps three pieces of state: a pending bit per level, a 32-bit enable mask, and the set of levels whose handlers have been entered and not yet returned. That last set acts as a nesting stack. It raises an interrupt toward the CPU only when the best enabled pending level outranks every level already in service.

While a request is raised, the controller presents four values. The first is the level number. The second is the descriptor that the CPU stores into the low byte of the interrupted context word. The third is the address of the level's save/load word pair inside the 0x800–0x9FF table. The fourth is a handler vector: the handler base address, modified by the XOR of the descriptor with a per-level 8-bit selector, so that each descriptor value lands on its own entry of a jump table. The CPU reads the base address and the selector from the level's new-context word and feeds them back in.

Software changes the mask with a command that has four modes: enable, disable, cancel, and cancel-then-enable. It leaves a handler with a return strobe, which drops the most urgent in-service level. Control then passes to the next level still in service, or to base code when none remains.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is all zeros and nothing is pending or in service, so `irqReq` is 0, and a request on any level leaves `irqReq` at 0 until that level is enabled.
- R2: When several enabled levels are pending, `irqLevel` shows the lowest-numbered one.
- R3: `irqReq` is 1 only if the best enabled pending level is strictly lower in number than every in-service level; a request on an equal or higher-numbered level waits.
- R4: A pending request on a disabled level stays pending and is presented as soon as its mask bit becomes 1.
- R5: A command with mask=1, cancel=0 sets every mask bit whose `cmdBits` bit is 1 and leaves the others unchanged.
- R6: A command with mask=0, cancel=0 clears every mask bit whose `cmdBits` bit is 0 and leaves the others unchanged.
- R7: A command with mask=0, cancel=1 clears the pending bit and the in-service bit of each level whose `cmdBits` bit is 1, and leaves the mask unchanged.
- R8: A command with mask=1, cancel=1 cancels the flagged levels as in R7 and, in the same cycle, enables them as in R5.
- R9: `irqDesc` is the descriptor of the presented level; a second request on a level that is already pending replaces its stored descriptor.
- R10: `vector` equals `handlerBase` XOR ((`handlerXorMask` XOR `irqDesc`) shifted left by 2), with the index zero-extended to 24 bits.
- R11: `pairAddr` equals 0x800 + 16 × `irqLevel` (level 0 at 0x800, level 31 at 0x9F0).
- R12: A return strobe removes the lowest-numbered in-service level; higher-numbered in-service levels stay active and keep blocking equal or lower-priority requests until they too are returned.
- R13: `irqAck` while `irqReq` is 1 moves the presented level from pending to in service, so a level that was requested several times before the acknowledge is taken only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe for one level this cycle |
| reqLvl | input | 5 | Level number of the request |
| reqDesc | input | 8 | Device descriptor carried with the request |
| irqAck | input | 1 | CPU takes the presented interrupt |
| retStrobe | input | 1 | Return from the current handler |
| cmdValid | input | 1 | Mask command strobe |
| cmdMask | input | 1 | Mask-bit field of the command |
| cmdCancel | input | 1 | Cancel-bit field of the command |
| cmdBits | input | 32 | Level operand of the command, bit n for level n |
| handlerBase | input | 24 | Handler address from the level's new-context word |
| handlerXorMask | input | 8 | Selector byte from the level's new-context word |
| irqReq | output | 1 | Interrupt request toward the CPU |
| irqLevel | output | 5 | Level being presented |
| irqDesc | output | 8 | Descriptor to save in the old-context word |
| pairAddr | output | 12 | Address of the level's context word pair |
| vector | output | 24 | Jump-table entry address |

## Verification
The hardest state to reach from the ports is a stack of nested in-service levels with blocked requests queued behind them. Only that state shows that a return resumes the right level and not base code. The stimulus enables every level, takes a low-priority level and then a more urgent one, and parks requests on an equal and a lower priority. Each return is followed by a check of `irqReq` and `irqLevel`. The cancel modes are reached the same way, by first placing a level in service and then cancelling it, so that its disappearance shows up as a less urgent request being let through.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_N  = 32;
  localparam int LVL_W  = $clog2(LVL_N);
  localparam int DESC_W = 8;

  typedef struct packed {
    logic             take;       // presented level moves pending -> in service
    logic [LVL_W-1:0] takeLvl;
    logic             retire;     // most urgent in-service level ends
    logic [LVL_W-1:0] retireLvl;
    logic             cancel;     // flagged levels lose pending and in-service
    logic             orMask;     // flagged levels enabled
    logic             andMask;    // unflagged levels disabled
  } ctlStrobe_t;

  function automatic logic [LVL_W-1:0] firstSet(input logic [LVL_N-1:0] v);
    logic [LVL_W-1:0] idx;
    idx = '0;
    for (int i = LVL_N - 1; i >= 0; i--) begin
      if (v[i]) idx = LVL_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic [LVL_N-1:0] pendVec,
  input  logic [LVL_N-1:0] maskVec,
  input  logic [LVL_N-1:0] inSvcVec,
  input  logic             irqAck,
  input  logic             retStrobe,
  input  logic             cmdValid,
  input  logic             cmdMask,
  input  logic             cmdCancel,
  output logic             irqReq,
  output logic [LVL_W-1:0] bestLvl,
  output ctlStrobe_t       strb
);
  logic [LVL_N-1:0] eligible;
  logic             activeValid;
  logic [LVL_W-1:0] activeLvl;

  always_comb begin
    eligible    = pendVec & maskVec;
    bestLvl     = firstSet(eligible);
    activeValid = |inSvcVec;
    activeLvl   = firstSet(inSvcVec);
    irqReq      = (|eligible) && (!activeValid || (bestLvl < activeLvl));

    strb.take      = irqReq && irqAck;
    strb.takeLvl   = bestLvl;
    strb.retire    = retStrobe && activeValid;
    strb.retireLvl = activeLvl;
    strb.cancel    = cmdValid && cmdCancel;
    strb.orMask    = cmdValid && cmdMask;
    strb.andMask   = cmdValid && !cmdMask && !cmdCancel;
  end
endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int                 ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]  TBL_BASE   = 12'h800,
  parameter int                 PAIR_SHIFT = 4,
  parameter int                 VEC_W      = 24,
  parameter int                 IDX_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              reqValid,
  input  logic [LVL_W-1:0]  reqLvl,
  input  logic [DESC_W-1:0] reqDesc,
  input  logic [LVL_N-1:0]  cmdBits,
  input  logic [LVL_W-1:0]  bestLvl,
  input  logic [VEC_W-1:0]  handlerBase,
  input  logic [DESC_W-1:0] handlerXorMask,
  output logic [LVL_N-1:0]  pendVec,
  output logic [LVL_N-1:0]  maskVec,
  output logic [LVL_N-1:0]  inSvcVec,
  output logic [DESC_W-1:0] irqDesc,
  output logic [ADDR_W-1:0] pairAddr,
  output logic [VEC_W-1:0]  vector
);
  logic [DESC_W-1:0] descReg [LVL_N];
  logic [DESC_W-1:0] tblIdx;

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    logic hitReq, hitTake, hitRetire, hitCancel;
    assign hitReq    = reqValid && (reqLvl == LVL_W'(g));
    assign hitTake   = strb.take && (strb.takeLvl == LVL_W'(g));
    assign hitRetire = strb.retire && (strb.retireLvl == LVL_W'(g));
    assign hitCancel = strb.cancel && cmdBits[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendVec[g]  <= 1'b0;
        inSvcVec[g] <= 1'b0;
        descReg[g]  <= '0;
      end else begin
        pendVec[g]  <= (pendVec[g] && !hitTake && !hitCancel) || hitReq;
        inSvcVec[g] <= (inSvcVec[g] && !hitRetire && !hitCancel) || hitTake;
        if (hitReq) descReg[g] <= reqDesc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskVec <= '0;
    else if (strb.andMask) maskVec <= maskVec & cmdBits;
    else if (strb.orMask)  maskVec <= maskVec | cmdBits;
  end

  always_comb begin
    irqDesc  = descReg[bestLvl];
    tblIdx   = irqDesc ^ handlerXorMask;
    pairAddr = TBL_BASE + (ADDR_W'(bestLvl) << PAIR_SHIFT);
    vector   = handlerBase ^ (VEC_W'(tblIdx) << IDX_SHIFT);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int                 ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]  TBL_BASE   = 12'h800,
  parameter int                 PAIR_SHIFT = 4,
  parameter int                 VEC_W      = 24,
  parameter int                 IDX_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LVL_W-1:0]  reqLvl,
  input  logic [DESC_W-1:0] reqDesc,
  input  logic              irqAck,
  input  logic              retStrobe,
  input  logic              cmdValid,
  input  logic              cmdMask,
  input  logic              cmdCancel,
  input  logic [LVL_N-1:0]  cmdBits,
  input  logic [VEC_W-1:0]  handlerBase,
  input  logic [DESC_W-1:0] handlerXorMask,
  output logic              irqReq,
  output logic [LVL_W-1:0]  irqLevel,
  output logic [DESC_W-1:0] irqDesc,
  output logic [ADDR_W-1:0] pairAddr,
  output logic [VEC_W-1:0]  vector
);
  logic [LVL_N-1:0] pendVec, maskVec, inSvcVec;
  ctlStrobe_t       strb;

  prio_irq_ctl u_ctl (
    .pendVec(pendVec), .maskVec(maskVec), .inSvcVec(inSvcVec),
    .irqAck(irqAck), .retStrobe(retStrobe),
    .cmdValid(cmdValid), .cmdMask(cmdMask), .cmdCancel(cmdCancel),
    .irqReq(irqReq), .bestLvl(irqLevel), .strb(strb)
  );

  prio_irq_dp #(
    .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .PAIR_SHIFT(PAIR_SHIFT),
    .VEC_W(VEC_W), .IDX_SHIFT(IDX_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqValid(reqValid), .reqLvl(reqLvl), .reqDesc(reqDesc),
    .cmdBits(cmdBits), .bestLvl(irqLevel),
    .handlerBase(handlerBase), .handlerXorMask(handlerXorMask),
    .pendVec(pendVec), .maskVec(maskVec), .inSvcVec(inSvcVec),
    .irqDesc(irqDesc), .pairAddr(pairAddr), .vector(vector)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqReq,
  input logic [LVL_W-1:0] irqLevel,
  input logic             irqAck,
  input logic             reqValid,
  input logic             cmdValid,
  input logic             cmdMask,
  input logic             cmdCancel,
  input logic [LVL_N-1:0] cmdBits,
  input logic [LVL_N-1:0] pendVec,
  input logic [LVL_N-1:0] maskVec,
  input logic [LVL_N-1:0] inSvcVec
);
  // R3
  preempt_strict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && (|inSvcVec)) |-> (irqLevel < firstSet(inSvcVec)));

  // R4
  presented_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (maskVec[irqLevel] && pendVec[irqLevel]));

  // R5
  enable_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdMask && !cmdCancel) |=> ((maskVec & $past(cmdBits)) == $past(cmdBits)));

  // R6
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdMask && !cmdCancel) |=> ((maskVec & ~$past(cmdBits)) == '0));

  // R7
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCancel && !reqValid && !irqAck)
      |=> (((pendVec | inSvcVec) & $past(cmdBits)) == '0));

  // R13
  take_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck && !cmdValid && !reqValid)
      |=> (inSvcVec[$past(irqLevel)] && !pendVec[$past(irqLevel)]));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqLevel(irqLevel),
  .irqAck(irqAck), .reqValid(reqValid), .cmdValid(cmdValid),
  .cmdMask(cmdMask), .cmdCancel(cmdCancel), .cmdBits(cmdBits),
  .pendVec(pendVec), .maskVec(maskVec), .inSvcVec(inSvcVec)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [4:0]  reqLvl;
  logic [7:0]  reqDesc;
  logic        irqAck, retStrobe;
  logic        cmdValid, cmdMask, cmdCancel;
  logic [31:0] cmdBits;
  logic [23:0] handlerBase;
  logic [7:0]  handlerXorMask;
  logic        irqReq;
  logic [4:0]  irqLevel;
  logic [7:0]  irqDesc;
  logic [11:0] pairAddr;
  logic [23:0] vector;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLvl(reqLvl), .reqDesc(reqDesc),
    .irqAck(irqAck), .retStrobe(retStrobe), .cmdValid(cmdValid), .cmdMask(cmdMask),
    .cmdCancel(cmdCancel), .cmdBits(cmdBits), .handlerBase(handlerBase),
    .handlerXorMask(handlerXorMask), .irqReq(irqReq), .irqLevel(irqLevel),
    .irqDesc(irqDesc), .pairAddr(pairAddr), .vector(vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 0; reqLvl = 0; reqDesc = 0; irqAck = 0; retStrobe = 0;
    cmdValid = 0; cmdMask = 0; cmdCancel = 0; cmdBits = 0;
    handlerBase = 24'h001000; handlerXorMask = 8'h0F;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic doReq(input int lvl, input logic [7:0] d);
    reqValid = 1; reqLvl = 5'(lvl); reqDesc = d;
    tick();
    reqValid = 0;
  endtask

  task automatic doCmd(input logic m, input logic c, input logic [31:0] bits);
    cmdValid = 1; cmdMask = m; cmdCancel = c; cmdBits = bits;
    tick();
    cmdValid = 0;
  endtask

  task automatic doAck();
    irqAck = 1; tick(); irqAck = 0;
  endtask

  task automatic doRet();
    retStrobe = 1; tick(); retStrobe = 0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 idle after reset", irqReq, 0);
    doReq(5, 8'h3C);
    chk("R1 masked by reset mask", irqReq, 0);
    doCmd(1, 0, 32'h0000_0020);
    chk("R5/R4 enabled level presented", irqReq, 1);
    chk("R4 level", irqLevel, 5);
    chk("R9 descriptor", irqDesc, 8'h3C);
    chk("R11 pair address lvl5", pairAddr, 12'h850);
    chk("R10 vector", vector, 24'h0010CC);
  endtask

  task automatic t_priority();
    doReset();
    doCmd(1, 0, 32'hFFFF_FFFF);
    doReq(31, 8'h01);
    chk("R11 pair address lvl31", pairAddr, 12'h9F0);
    doReq(9, 8'h02);
    doReq(3, 8'h03);
    chk("R2 best level", irqLevel, 3);
    doReq(0, 8'h04);
    chk("R2 level 0 wins", irqLevel, 0);
    chk("R11 pair address lvl0", pairAddr, 12'h800);
  endtask

  task automatic t_nesting();
    doReset();
    doCmd(1, 0, 32'hFFFF_FFFF);
    doReq(7, 8'h10);
    doAck();
    chk("R13 taken level leaves pending", irqReq, 0);
    doReq(9, 8'h11);
    chk("R3 lower priority blocked", irqReq, 0);
    doReq(7, 8'h12);
    chk("R3 equal priority blocked", irqReq, 0);
    doReq(2, 8'h13);
    chk("R3 higher priority preempts", irqReq, 1);
    chk("R3 preempt level", irqLevel, 2);
    doAck();
    chk("R3 nothing outranks 2", irqReq, 0);
    doRet();
    chk("R12 level 7 still active blocks 7 and 9", irqReq, 0);
    doRet();
    chk("R12 base resumed, pending 7 presented", irqReq, 1);
    chk("R12 next level", irqLevel, 7);
    chk("R9 overwritten descriptor", irqDesc, 8'h12);
  endtask

  task automatic t_disable();
    doReset();
    doCmd(1, 0, 32'hFFFF_FFFF);
    doReq(4, 8'h20);
    doCmd(0, 0, ~32'h0000_0010);
    chk("R6 zero bit disables level 4", irqReq, 0);
    doReq(8, 8'h21);
    chk("R6 one bits keep level 8 enabled", irqLevel, 8);
    doCmd(1, 0, 32'h0000_0010);
    chk("R4 held request returns", irqLevel, 4);
  endtask

  task automatic t_cancel();
    doReset();
    doCmd(1, 0, 32'hFFFF_FFFF);
    doReq(6, 8'h30);
    doAck();
    doReq(10, 8'h31);
    chk("R7 level 10 blocked by 6", irqReq, 0);
    doCmd(0, 1, 32'h0000_0440);
    chk("R7 cancelled pending gone", irqReq, 0);
    doReq(12, 8'h32);
    chk("R7 in-service 6 cancelled, mask kept", irqReq, 1);
    chk("R7 level 12 presented", irqLevel, 12);
  endtask

  task automatic t_cancelEnable();
    doReset();
    doReq(11, 8'h40);
    doCmd(1, 1, 32'h0000_0800);
    chk("R8 pending cancelled before enable", irqReq, 0);
    doReq(11, 8'h41);
    chk("R8 level now enabled", irqReq, 1);
    chk("R8 level", irqLevel, 11);
  endtask

  task automatic t_descriptor();
    doReset();
    doCmd(1, 0, 32'hFFFF_FFFF);
    handlerBase = 24'hABC000; handlerXorMask = 8'hF0;
    doReq(20, 8'h11);
    doReq(20, 8'hA5);
    chk("R9 replaced descriptor", irqDesc, 8'hA5);
    chk("R10 vector second base", vector, 24'hABC000 ^ 24'h000154);
    doAck();
    chk("R13 single take", irqReq, 0);
    doRet();
    chk("R13 not queued twice", irqReq, 0);
  endtask

  initial begin
    #(8 * 50000);
    nFail++; nChk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_nesting();
    t_disable();
    t_cancel();
    t_cancelEnable();
    t_descriptor();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule